// File: doc/BRIEF.md
# Input-Capture Timer with Optional Restart

This block is a free-running up-counter that stamps the moment an external signal changes. The count advances at the system clock divided by a power of two. When the chosen edge of the timer input arrives, the current count is latched into a capture register. Software can measure the time from start to event as (captured count − start count) × divide ratio / clock frequency.

Two capture styles are selectable. In plain capture the counter keeps running after the stamp. In restart capture the counter also jumps back to 0001h, so each stamp gives the interval since the previous event. If no event arrives, the counter climbs to a programmed compare value, wraps to 0001h and raises a reload event. One interrupt line reports both kinds of event. A source flag, together with a capture register that software can clear to zero, tells the handler which event fired. A selector can mask either event kind.

Top module: `icap_timer`

## Requirements
- R1: After reset every register reads 0000h and `irq` is low.
- R2: While the enable bit (control bit 0) is 0, the count holds its value, the prescaler stays cleared, no capture is taken, and no interrupt is raised.
- R3: The prescale exponent (control bits 5:3, value n) makes the count advance once every 2^n clocks. The first advance comes 2^n clocks after the enable takes effect.
- R4: The timer input passes through two synchroniser flops. A capture copies the count held three clocks after the input change into the capture register (address 3). Control bit 2 = 0 selects rising edges and 1 selects falling edges. Edges of the other direction are ignored.
- R5: In plain capture mode (control bit 1 = 0) the count keeps advancing through a capture.
- R6: In restart mode (control bit 1 = 1) a capture sets the count to 0001h.
- R7: When the count equals the compare value (address 2) on a prescaler tick, the next count is 0001h and a reload event occurs.
- R8: The source flag (control read-back bit 8, read-only) is set by a capture event and cleared by a reload event.
- R9: The interrupt selector (control bits 7:6) works as follows: 00 or 01 report both events, 10 reports only captures, 11 reports only reloads.
- R10: `irq` is high for the clock after each reported event and low otherwise.
- R11: When a capture and a compare match fall on the same clock, the capture wins. The flag is set, the count becomes 0001h, and no reload event is reported.
- R12: An input held at its new level yields exactly one capture.
- R13: The count (address 1), compare (address 2) and capture (address 3) registers are writable. A software write takes precedence over a hardware update on the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 control, 1 count, 2 compare, 3 capture |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| tmr_in | input | 1 | Asynchronous external timer input |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench targets a capture edge that lands on the same clock as a compare match. A design with the wrong priority would clear the source flag or report a reload instead of the capture. It holds the input high for many clocks after an edge; a level-sensitive detector would restamp and interrupt every clock. It measures the synchroniser latency exactly through the captured value, which exposes a missing or extra flop. It runs the largest divide ratio and the prescaler restart at enable, which exposes off-by-one tick placement. Each interrupt-selector setting is exercised against the event kind it should hide.

// File: rtl/icap_pkg.sv
package icap_pkg;
   localparam int unsigned PS_W = 3;

   typedef enum logic [1:0] {
      IRQ_BOTH     = 2'b00,
      IRQ_BOTH_ALT = 2'b01,
      IRQ_CAP_ONLY = 2'b10,
      IRQ_REL_ONLY = 2'b11
   } irq_sel_e;

   typedef struct packed {
      irq_sel_e        irq_sel;
      logic [PS_W-1:0] ps_exp;
      logic            falling;
      logic            restart;
      logic            enable;
   } ctrl_t;

   localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/icap_edge_sync.sv
module icap_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic falling,
   output logic edge_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("icap_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] chain_q;
   logic            synced;
   logic            prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-1:0], pin};
   end

   assign synced = chain_q[STAGES-1];
   assign prev   = chain_q[STAGES];
   assign edge_o = falling ? (prev & ~synced) : (~prev & synced);

   p_single_edge_r12: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o |=> !edge_o)
      else $error("R12: edge seen on consecutive clocks");
endmodule

// File: rtl/icap_prescaler.sv
module icap_prescaler #(
   parameter int unsigned EXP_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [EXP_W-1:0] exp_sel,
   output logic             tick
);
   localparam int unsigned DIV_W = (1 << EXP_W) - 1;

   if (EXP_W == 0) begin : g_no_div
      assign tick = run;
   end else begin : g_div
      logic [DIV_W-1:0] div_q;
      logic [DIV_W-1:0] mask;

      assign mask = (DIV_W'(1) << exp_sel) - DIV_W'(1);
      assign tick = run && ((div_q & mask) == mask);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    div_q <= '0;
         else if (!run) div_q <= '0;
         else           div_q <= div_q + DIV_W'(1);
      end

      p_zero_exp_ticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (run && $past(run) && exp_sel == '0) |-> tick)
         else $error("R3: divide-by-one missed a tick");
   end
endmodule

// File: rtl/icap_core.sv
module icap_core
   import icap_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             restart,
   input  irq_sel_e         irq_sel,
   input  logic             tick,
   input  logic             cap_edge,
   input  logic             cnt_we,
   input  logic             cap_we,
   input  logic [CNT_W-1:0] wdata,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] count_q,
   output logic [CNT_W-1:0] capture_q,
   output logic             flag_q,
   output logic             irq_q
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic cap_evt;
   logic match;
   logic rel_evt;

   assign cap_evt = en && cap_edge;
   assign match   = tick && (count_q == reload);
   assign rel_evt = match && !cap_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q   <= '0;
         capture_q <= '0;
         flag_q    <= 1'b0;
         irq_q     <= 1'b0;
      end else begin
         irq_q <= (cap_evt && irq_sel != IRQ_REL_ONLY) ||
                  (rel_evt && irq_sel != IRQ_CAP_ONLY);

         if (cap_evt)      flag_q <= 1'b1;
         else if (rel_evt) flag_q <= 1'b0;

         if (cnt_we)                              count_q <= wdata;
         else if ((cap_evt && restart) || match) count_q <= ONE;
         else if (tick)                           count_q <= count_q + ONE;

         if (cap_we)       capture_q <= wdata;
         else if (cap_evt) capture_q <= count_q;
      end
   end

   p_hold_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !cnt_we) |=> $stable(count_q))
      else $error("R2: count moved while disabled");

   p_restart_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_evt && restart && !cnt_we) |=> (count_q == ONE))
      else $error("R6: restart did not load 0001h");

   p_reload_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_evt && !cnt_we) |=> (count_q == ONE))
      else $error("R7: reload did not load 0001h");

   p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> flag_q)
      else $error("R8: flag not set by capture");

   p_flag_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rel_evt |=> !flag_q)
      else $error("R8: flag not cleared by reload");

   p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> $past(cap_evt || rel_evt))
      else $error("R10: interrupt without an event");

   p_cap_priority_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_evt && match) |=> flag_q)
      else $error("R11: coincident reload overrode capture");
endmodule

// File: rtl/icap_timer.sv
module icap_timer
   import icap_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       reg_addr,
   input  logic             reg_wr,
   input  logic [CNT_W-1:0] reg_wdata,
   output logic [CNT_W-1:0] reg_rdata,
   input  logic             tmr_in,
   output logic             irq
);
   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_CNT  = 2'd1;
   localparam logic [1:0] A_CMP  = 2'd2;
   localparam logic [1:0] A_CAP  = 2'd3;

   if (CNT_W < CTRL_W + 1) begin : g_bad_width
      $error("icap_timer: CNT_W too narrow for control read-back");
   end

   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] capture;
   logic             flag;
   logic             tick;
   logic             cap_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         reload_q <= '0;
      end else if (reg_wr) begin
         if (reg_addr == A_CTRL) ctrl_q   <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
         if (reg_addr == A_CMP)  reload_q <= reg_wdata;
      end
   end

   icap_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin     (tmr_in),
      .falling (ctrl_q.falling),
      .edge_o  (cap_edge)
   );

   icap_prescaler #(.EXP_W(PS_W)) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ctrl_q.enable),
      .exp_sel (ctrl_q.ps_exp),
      .tick    (tick)
   );

   icap_core #(.CNT_W(CNT_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (ctrl_q.enable),
      .restart   (ctrl_q.restart),
      .irq_sel   (ctrl_q.irq_sel),
      .tick      (tick),
      .cap_edge  (cap_edge),
      .cnt_we    (reg_wr && reg_addr == A_CNT),
      .cap_we    (reg_wr && reg_addr == A_CAP),
      .wdata     (reg_wdata),
      .reload    (reload_q),
      .count_q   (count),
      .capture_q (capture),
      .flag_q    (flag),
      .irq_q     (irq)
   );

   always_comb begin
      unique case (reg_addr)
         A_CTRL:  reg_rdata = CNT_W'({flag, ctrl_q});
         A_CNT:   reg_rdata = count;
         A_CMP:   reg_rdata = reload_q;
         default: reg_rdata = capture;
      endcase
   end

   p_no_irq_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.enable && !$past(ctrl_q.enable)) |-> !irq)
      else $error("R2: interrupt while disabled");
endmodule

// File: tb/icap_timer_bench.sv
module icap_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  reg_addr = 2'd1;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        tmr_in = 1'b0;
   logic        irq;

   int n_cmp = 0;
   int n_bad = 0;
   int irq_cnt = 0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   icap_timer u_icap_timer (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_in(tmr_in), .irq(irq)
   );

   // behavioural reference
   int m_cnt, m_rel, m_cap, m_ctrl, m_pre, m_flag, m_irq, s1, s2, s3;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt = 0; m_rel = 0; m_cap = 0; m_ctrl = 0; m_pre = 0;
         m_flag = 0; m_irq = 0; s1 = 0; s2 = 0; s3 = 0;
      end else begin
         int en, rs, fal, ps, sel, msk, edg, tk, cap, mt, rel;
         int n_cnt, n_cap;
         en  = m_ctrl & 1;
         rs  = (m_ctrl >> 1) & 1;
         fal = (m_ctrl >> 2) & 1;
         ps  = (m_ctrl >> 3) & 7;
         sel = (m_ctrl >> 6) & 3;
         msk = (1 << ps) - 1;
         edg = fal ? (s3 == 1 && s2 == 0) : (s3 == 0 && s2 == 1);
         tk  = en && ((m_pre & msk) == msk);
         cap = en && edg;
         mt  = tk && (m_cnt == m_rel);
         rel = mt && !cap;
         if (reg_wr && reg_addr == 2'd1) n_cnt = int'(reg_wdata);
         else if ((cap && rs) || mt)     n_cnt = 1;
         else if (tk)                    n_cnt = (m_cnt + 1) % 65536;
         else                            n_cnt = m_cnt;
         if (reg_wr && reg_addr == 2'd3) n_cap = int'(reg_wdata);
         else if (cap)                   n_cap = m_cnt;
         else                            n_cap = m_cap;
         m_irq = ((cap && sel != 3) || (rel && sel != 2)) ? 1 : 0;
         if (cap) m_flag = 1; else if (rel) m_flag = 0;
         m_pre = en ? (m_pre + 1) % 128 : 0;
         if (reg_wr && reg_addr == 2'd0) m_ctrl = int'(reg_wdata) & 255;
         if (reg_wr && reg_addr == 2'd2) m_rel = int'(reg_wdata);
         m_cnt = n_cnt;
         m_cap = n_cap;
         s3 = s2; s2 = s1; s1 = int'(tmr_in);
      end
   end

   function automatic int m_read(input logic [1:0] a);
      case (a)
         2'd0:    return (m_flag << 8) | m_ctrl;
         2'd1:    return m_cnt;
         2'd2:    return m_rel;
         default: return m_cap;
      endcase
   endfunction

   // compare every clock, away from the edge
   always @(posedge clk) begin
      #5;
      n_cmp++;
      if (irq !== m_irq[0] || int'(reg_rdata) != m_read(reg_addr)) begin
         n_bad++;
         $display("FAIL %s cycle compare: irq=%0b rdata=%h expected irq=%0b rdata=%h",
                  cur_req, irq, reg_rdata, m_irq[0], m_read(reg_addr));
      end
      if (irq) irq_cnt++;
   end

   task automatic check(input string req, input int got, input int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d (%h) expected %0d (%h)", req, got, got, exp, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input int d);
      @(negedge clk);
      reg_addr = a; reg_wdata = 16'(d); reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = 2'd1;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      @(negedge clk);
      reg_addr = a;
      @(posedge clk); #5;
      v = int'(reg_rdata);
      @(negedge clk);
      reg_addr = 2'd1;
   endtask

   function automatic int ctl(input int en, input int rs, input int fal,
                              input int ps, input int sel);
      return (sel << 6) | (ps << 3) | (fal << 2) | (rs << 1) | en;
   endfunction

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      int v, c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      cur_req = "R1";
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v);
         check("R1 reset register", v, 0);
      end
      check("R1 irq low", int'(irq), 0);

      // R2 disabled: count holds, pin ignored
      cur_req = "R2";
      wr(2'd1, 7);
      irq_cnt = 0;
      repeat (4) begin
         @(negedge clk) tmr_in = 1'b1;
         repeat (4) @(negedge clk);
         tmr_in = 1'b0;
         repeat (4) @(negedge clk);
      end
      check("R2 count held", int'(reg_rdata), 7);
      rd(2'd3, v);
      check("R2 no capture while off", v, 0);
      check("R2 no irq while off", irq_cnt, 0);

      // R7 reload at compare, R10 pulse
      cur_req = "R7";
      wr(2'd1, 0);
      wr(2'd2, 5);
      wr(2'd0, ctl(1, 0, 0, 0, 0));
      repeat (6) @(posedge clk);
      #5;
      check("R7 count wraps to 1", int'(reg_rdata), 1);
      check("R10 irq on reload", int'(irq), 1);
      @(posedge clk); #5;
      check("R10 irq single clock", int'(irq), 0);
      rd(2'd0, v);
      check("R8 flag clear after reload", (v >> 8) & 1, 0);

      // R3 prescale divide by 4 and 128
      cur_req = "R3";
      wr(2'd0, ctl(0, 0, 0, 2, 0));
      wr(2'd1, 0);
      wr(2'd2, 16'hFFFF);
      wr(2'd0, ctl(1, 0, 0, 2, 0));
      repeat (40) @(posedge clk);
      #5;
      check("R3 divide by 4 after 40 clocks", int'(reg_rdata), 10);
      wr(2'd0, ctl(0, 0, 0, 7, 0));
      wr(2'd1, 0);
      wr(2'd0, ctl(1, 0, 0, 7, 0));
      repeat (256) @(posedge clk);
      #5;
      check("R3 divide by 128 after 256 clocks", int'(reg_rdata), 2);

      // R4/R5 plain capture, rising then falling
      cur_req = "R4";
      wr(2'd0, ctl(0, 0, 0, 0, 0));
      wr(2'd1, 100);
      wr(2'd3, 0);
      wr(2'd0, ctl(1, 0, 0, 0, 0));
      repeat (5) @(negedge clk);
      c = int'(reg_rdata);
      tmr_in = 1'b1;
      repeat (6) @(negedge clk);
      check("R5 count keeps running", int'(reg_rdata), c + 6);
      rd(2'd3, v);
      check("R4 rising capture value", v, c + 2);
      rd(2'd0, v);
      check("R8 flag set by capture", (v >> 8) & 1, 1);
      tmr_in = 1'b0;
      repeat (6) @(negedge clk);
      wr(2'd0, ctl(1, 0, 1, 0, 0));
      repeat (3) @(negedge clk);
      tmr_in = 1'b1;
      repeat (6) @(negedge clk);
      rd(2'd3, v);
      check("R4 rising ignored in falling mode", v, c + 2);
      @(negedge clk);
      c = int'(reg_rdata);
      tmr_in = 1'b0;
      repeat (6) @(negedge clk);
      rd(2'd3, v);
      check("R4 falling capture value", v, c + 2);

      // R6 restart, R12 one capture per held level, R9 capture-only
      cur_req = "R6";
      wr(2'd2, 16'hFFFF);
      wr(2'd0, ctl(1, 1, 0, 0, 2));
      repeat (4) @(negedge clk);
      irq_cnt = 0;
      tmr_in = 1'b1;
      repeat (3) @(posedge clk);
      #5;
      check("R6 restart loads 1", int'(reg_rdata), 1);
      repeat (60) @(negedge clk);
      check("R12 single capture for held level", irq_cnt, 1);

      // R9 reload-only hides capture
      cur_req = "R9";
      wr(2'd0, ctl(1, 0, 0, 0, 3));
      tmr_in = 1'b0;
      repeat (6) @(negedge clk);
      irq_cnt = 0;
      tmr_in = 1'b1;
      repeat (8) @(negedge clk);
      check("R9 reload-only hides capture", irq_cnt, 0);
      // capture-only hides reloads
      wr(2'd0, ctl(0, 0, 0, 0, 2));
      wr(2'd1, 0);
      wr(2'd2, 3);
      wr(2'd0, ctl(1, 0, 0, 0, 2));
      irq_cnt = 0;
      repeat (40) @(negedge clk);
      check("R9 capture-only hides reload", irq_cnt, 0);
      wr(2'd0, ctl(1, 0, 0, 0, 1));
      irq_cnt = 0;
      repeat (12) @(negedge clk);
      check("R9 selector 01 reports reloads", (irq_cnt > 0) ? 1 : 0, 1);

      // R11 coincident capture and compare match
      cur_req = "R11";
      wr(2'd0, ctl(0, 0, 0, 0, 0));
      tmr_in = 1'b0;
      wr(2'd1, 0);
      wr(2'd2, 40);
      wr(2'd3, 0);
      repeat (4) @(negedge clk);
      wr(2'd0, ctl(1, 0, 0, 0, 0));
      while (m_cnt != 38) @(negedge clk);
      tmr_in = 1'b1;
      repeat (3) @(posedge clk);
      #5;
      check("R11 count restarts at 1", int'(reg_rdata), 1);
      check("R11 irq raised", int'(irq), 1);
      rd(2'd0, v);
      check("R11 flag marks capture", (v >> 8) & 1, 1);
      rd(2'd3, v);
      check("R11 captured compare value", v, 40);

      // R13 software writes win
      cur_req = "R13";
      wr(2'd3, 0);
      rd(2'd3, v);
      check("R13 capture cleared by write", v, 0);
      wr(2'd2, 16'hFFFF);
      wr(2'd1, 500);
      @(posedge clk); #5;
      check("R13 count write then advance", int'(reg_rdata), 501);

      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule